// File: doc/BRIEF.md
# Edge-Limited Data Output Synchroniser

This block drives the receiver's serial data output from the raw bit of the demodulator. The raw bit arrives asynchronously. It passes through a two-flop synchroniser, and the output register then takes its value only on cycles where a slower extended-cycle tick is asserted. After each output edge a hold counter blocks any further change until a fixed number of ticks has passed. This removes short spikes and limits how often a downstream microcontroller can be interrupted by data edges.

An output-enable gate selects between two states. While the gate is low, the output rests at its idle high level. When the gate rises, the output takes the current synchronised raw value at once and the hold counter starts cleared. The tick generator and the sequencing of receiver modes sit outside this block.

Top module: `edge_limited_data`

## Requirements
- R1: While the gate stays high, `data_o` changes only in the clock cycle after an edge at which `tick_i` was 1. Every interval between two output edges is therefore an integer number of tick periods.
- R2: Two consecutive output edges, with the gate high throughout, are at least MIN_GAP (default 10) ticks apart. A raw level lasting fewer than MIN_GAP ticks from a settled state gives an output level that lasts exactly MIN_GAP ticks.
- R3: From a settled state, a raw level that lasts at least MIN_GAP ticks is reproduced on `data_o` with the same length in ticks. The first edge follows the raw change after 3 to 2+P clock cycles, where P is the tick period in cycles.
- R4: If the raw bit changes and changes back inside the hold window that follows an output edge, no output edge results.
- R5: During reset, and in the cycle after any clock edge at which `gate_i` is 0, `data_o` is 1 (idle high), whatever the raw bit does.
- R6: At the first clock edge with `gate_i` = 1 after it was 0, `data_o` loads the synchronised raw value. The hold counter is cleared, so a raw change that follows at once reaches `data_o` after 3 to 2+P cycles, with no hold wait.
- R7: When the gate opens at the same edge as a tick, the load of R6 takes priority over any tick-driven update, and the hold counter is left cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Extended-cycle tick, one clock cycle wide |
| raw_i | input | 1 | Raw demodulator bit, asynchronous |
| gate_i | input | 1 | Output enable; 0 forces the idle high level |
| data_o | output | 1 | Limited, tick-quantised data output |

## Verification
The gate opening and an extended-cycle tick can land on the same clock edge, so the reload and a tick-driven update or hold-counter step compete in one cycle. The bench provokes this by raising the gate, with the raw bit low, on the negative edge just before a known tick edge. It then requires `data_o` to be low in the next cycle. It also requires a raw rise driven straight afterwards to appear within 2+P cycles, which shows that no hold was armed. A second collision, a tick at which the hold expires while the raw bit differs, is covered by the pulse sweep. That sweep measures output lengths of exactly MIN_GAP ticks.

// File: rtl/edl_pkg.sv
package edl_pkg;
  // Action taken by the output register in a cycle
  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_IDLE = 2'd1,
    ACT_LOAD = 2'd2,
    ACT_EDGE = 2'd3
  } act_e;
endpackage

// File: rtl/edl_rst_sync.sv
module edl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/edl_bit_sync.sv
module edl_bit_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      logic d_in;
      if (i == 0) begin : g_first
        assign d_in = din;
      end else begin : g_next
        assign d_in = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= RESET_VAL;
        else        stage_q[i] <= d_in;
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/edl_hold_ctr.sv
module edl_hold_ctr #(
  parameter int MIN_GAP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic load,
  output logic expired
);
  localparam int              CW       = $clog2(MIN_GAP + 1);
  localparam logic [CW-1:0]   LOAD_VAL = CW'(MIN_GAP - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (load) begin
      cnt_d  = LOAD_VAL;
      cnt_en = 1'b1;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL); // R2
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> expired); // R7
endmodule

// File: rtl/edl_out_stage.sv
module edl_out_stage
  import edl_pkg::*;
#(
  parameter int MIN_GAP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw_s,
  input  logic gate,
  input  logic expired,
  output act_e act,
  output logic data
);
  localparam int            CW      = $clog2(MIN_GAP + 1);
  localparam logic [CW-1:0] GAP_SAT = CW'(MIN_GAP);

  logic gate_q;
  logic data_q;
  logic data_d;

  always_comb begin
    act    = ACT_KEEP;
    data_d = data_q;
    if (!gate) begin
      act    = ACT_IDLE;
      data_d = 1'b1;
    end else if (!gate_q) begin
      act    = ACT_LOAD;
      data_d = raw_s;
    end else if (tick && expired && (raw_s != data_q)) begin
      act    = ACT_EDGE;
      data_d = raw_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      data_q <= 1'b1;
    end else begin
      gate_q <= gate;
      if (act != ACT_KEEP) data_q <= data_d;
    end
  end

  assign data = data_q;

  // Checker state: ticks elapsed since the last tick-driven edge
  logic [CW-1:0] since_q;
  logic          armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      armed_q <= 1'b0;
    end else if (act == ACT_EDGE) begin
      since_q <= '0;
      armed_q <= 1'b1;
    end else if (act == ACT_IDLE || act == ACT_LOAD) begin
      since_q <= '0;
      armed_q <= 1'b0;
    end else if (tick && since_q < GAP_SAT) begin
      since_q <= since_q + 1'b1;
    end
  end

  AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_EDGE && armed_q) |-> (int'(since_q) + 1 >= MIN_GAP)); // R2
  AST_QUIET_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && gate_q && !tick) |=> $stable(data_q)); // R1
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> data_q); // R5
  AST_OPEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !gate_q) |=> (data_q == $past(raw_s))); // R6
endmodule

// File: rtl/edge_limited_data.sv
module edge_limited_data
  import edl_pkg::*;
#(
  parameter int MIN_GAP     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic raw_i,
  input  logic gate_i,
  output logic data_o
);
  logic rst_n_s;
  logic raw_s;
  logic expired;
  act_e act;

  edl_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  edl_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .din   (raw_i),
    .dout  (raw_s)
  );

  edl_hold_ctr #(.MIN_GAP(MIN_GAP)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick    (tick_i),
    .clr     (act == ACT_IDLE || act == ACT_LOAD),
    .load    (act == ACT_EDGE),
    .expired (expired)
  );

  edl_out_stage #(.MIN_GAP(MIN_GAP)) u_out (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick    (tick_i),
    .raw_s   (raw_s),
    .gate    (gate_i),
    .expired (expired),
    .act     (act),
    .data    (data_o)
  );

  AST_EDGE_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (act == ACT_EDGE) |-> expired); // R2
endmodule

// File: tb/sim_edge_limited_data.sv
`timescale 1ns/1ps
module sim_edge_limited_data;
  localparam int GAP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic raw_i = 1'b1;
  logic gate_i = 1'b0;
  logic data_o;

  edge_limited_data #(.MIN_GAP(GAP), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .raw_i(raw_i), .gate_i(gate_i), .data_o(data_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int per = 1;
  int tcnt = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tcnt >= per - 1) begin tcnt <= 0; tick_i <= 1'b1; end
    else begin tcnt <= tcnt + 1; tick_i <= 1'b0; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Output edge monitor
  logic prev_d = 1'b1;
  int nfall = 0, nrise = 0, fall_cyc = 0, rise_cyc = 0, last_cyc = 0;
  bit have_last = 0, mon_gap = 0;

  always @(negedge clk) begin
    if (rst_n && data_o !== prev_d) begin
      if (data_o == 1'b0) begin nfall++; fall_cyc = cyc; end
      else begin nrise++; rise_cyc = cyc; end
      if (mon_gap && have_last) begin
        chk(((cyc - last_cyc) % per) == 0, "R1", "edge interval not tick multiple",
            (cyc - last_cyc) % per, 0);
        chk((cyc - last_cyc) >= GAP * per, "R2", "edge interval below min gap",
            cyc - last_cyc, GAP * per);
      end
      have_last = 1;
      last_cyc = cyc;
    end
    prev_d = data_o;
  end

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mon();
    nfall = 0; nrise = 0; have_last = 0;
  endtask

  task automatic pulse(input int w);
    int t0;
    int exp_len;
    clear_mon();
    t0 = cyc;
    raw_i = 1'b0;
    waitn(w * per);
    raw_i = 1'b1;
    waitn((GAP + w + 8) * per + 4);
    exp_len = (w >= GAP) ? w * per : GAP * per;
    chk(nfall == 1, (w >= GAP) ? "R3" : "R2", "fall count", nfall, 1);
    chk(nrise == 1, (w >= GAP) ? "R3" : "R2", "rise count", nrise, 1);
    chk(rise_cyc - fall_cyc == exp_len, (w >= GAP) ? "R3" : "R2", "low length",
        rise_cyc - fall_cyc, exp_len);
    chk((fall_cyc - t0) >= 3 && (fall_cyc - t0) <= 2 + per, "R3", "first edge delay",
        fall_cyc - t0, 2 + per);
  endtask

  task automatic glitch();
    clear_mon();
    raw_i = 1'b0; waitn(3 * per);
    raw_i = 1'b1; waitn(3 * per);
    raw_i = 1'b0; waitn(14 * per);
    raw_i = 1'b1; waitn(30 * per + 6);
    chk(nfall == 1, "R4", "fall count with revert in hold", nfall, 1);
    chk(nrise == 1, "R4", "rise count with revert in hold", nrise, 1);
    chk(rise_cyc - fall_cyc == 20 * per, "R4", "low length with revert",
        rise_cyc - fall_cyc, 20 * per);
  endtask

  task automatic square(input int h);
    for (int k = 0; k < 6; k++) begin
      raw_i = ~raw_i;
      waitn(h * per);
    end
    waitn(2 * (GAP + 4) * per);
    chk(data_o == 1'b1, "R3", "settles to raw level after square", data_o, 1);
  endtask

  task automatic follow_delay(input string req);
    int t0;
    int d;
    raw_i = 1'b1;
    t0 = cyc;
    for (int k = 0; k < 40 * per && data_o != 1'b1; k++) @(negedge clk);
    d = cyc - t0;
    chk(data_o == 1'b1 && d >= 3 && d <= 2 + per, req, "raw rise after open, cycles",
        d, 2 + per);
  endtask

  initial begin
    rst_n = 1'b0;
    waitn(4);
    chk(data_o == 1'b1, "R5", "reset level", data_o, 1);
    rst_n = 1'b1;
    waitn(6);
    chk(data_o == 1'b1, "R5", "gate closed after reset", data_o, 1);

    for (int pi = 0; pi < 2; pi++) begin
      per = (pi == 0) ? 1 : 3;
      gate_i = 1'b0; raw_i = 1'b1;
      waitn(10);
      gate_i = 1'b1;
      waitn(6);
      for (int w = 1; w <= 16; w++) pulse(w);
      glitch();
      clear_mon();
      mon_gap = 1;
      for (int h = 1; h <= 12; h++) square(h);
      mon_gap = 0;

      // R5: closing the gate forces idle high
      raw_i = 1'b0;
      waitn(20 * per);
      chk(data_o == 1'b0, "R5", "low before gate close", data_o, 0);
      gate_i = 1'b0;
      waitn(1);
      chk(data_o == 1'b1, "R5", "idle high one cycle after close", data_o, 1);
      for (int k = 0; k < 20; k++) begin
        raw_i = k[1];
        waitn(1);
        chk(data_o == 1'b1, "R5", "idle high while raw toggles", data_o, 1);
      end

      // R6: opening with raw low loads it at once, no hold armed
      raw_i = 1'b0;
      waitn(4);
      gate_i = 1'b1;
      waitn(1);
      chk(data_o == 1'b0, "R6", "loads raw low on open", data_o, 0);
      follow_delay("R6");

      // R7: open coincides with a tick
      gate_i = 1'b0; raw_i = 1'b0;
      waitn(6);
      while (tick_i != 1'b1) @(negedge clk);
      gate_i = 1'b1;
      waitn(1);
      chk(data_o == 1'b0, "R7", "load wins over tick on open", data_o, 0);
      follow_delay("R7");
      waitn(GAP * per + 4);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule